// File: doc/BRIEF.md
# Sequence-Indexed Packet Reorder Buffer

This block takes fixed-size packets from a network receive stream in the input clock domain. Packets may arrive out of order, in bursts, or not at all. Each packet opens with a short header, and the low bits of its first header word carry a sequence number. The block places the packet's payload into a slot of a dual-clock packet memory. The slot is chosen by the sequence number modulo the slot count, not by arrival order. The other header words, which hold a time stamp, are not used.

On the output clock, the block plays the slots back as an unbroken word stream in strict sequence order. It rebuilds a frame marker on the first word of every slot period and a data-valid flag. A slot that never received its packet is played as a fill word with data-valid low, so the output timing stays the same. Playback begins only once a programmable number of slots hold data. After that it never pauses, so the buffer absorbs network jitter.

A packet whose sequence number falls outside the acceptance window is dropped and counted as late. The window holds SLOTS-1 numbers and starts at the next slot the output will open. A production build uses 512 slots of 2048 words. The default parameters are reduced so that elaboration stays small. SLOTS and PKT_WORDS must be powers of two, PKT_WORDS must be at least 2, and SEQ_W must be wider than log2(SLOTS).

Top module: `seq_reorder_buf`

## Requirements
- R1: in_ready is high in every cycle after the first input-clock edge that follows release of wr_rst_n. A word is taken on each edge where in_valid and in_ready are both high. A packet is HDR_WORDS header words followed by PKT_WORDS payload words. Its sequence number is bits [SEQ_W-1:0] of the first header word. All other header bits are ignored.
- R2: The payload of an accepted packet with sequence number s is stored in slot s mod SLOTS. The output plays slots in increasing sequence order, starting with sequence 0, whatever order the packets arrived in.
- R3: Let P be the sequence number the output will open next. A packet is accepted only if (s - P) mod 2^SEQ_W < SLOTS-1, both when its header arrives and when its last word arrives. Otherwise none of its payload reaches the output.
- R4: late_cnt is 0 after reset and rises by exactly one for each rejected packet.
- R5: After reset, out_run, out_dvalid and out_sync are low and out_data equals FILL_WORD. out_run stays low until the number of filled slots is at least start_fill, then rises and stays high.
- R6: While running, one word leaves per rd_clk cycle with no gaps. out_sync is high on the first word of every slot period and nowhere else, so it recurs every PKT_WORDS cycles.
- R7: A slot with no packet plays as PKT_WORDS words of FILL_WORD with out_dvalid low, and its out_sync still appears.
- R8: A filled slot plays its PKT_WORDS payload words in order with out_dvalid high on each.
- R9: Playing a slot clears its filled state. If the packet one lap later (s+SLOTS) is missing, that slot plays as fill, not as the old data.
- R10: Sequence arithmetic wraps modulo 2^SEQ_W, so playback and acceptance continue seamlessly across the wrap of the sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input (network side) clock |
| wr_rst_n | input | 1 | Active-low reset, input domain |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block takes words; no back-pressure after reset |
| in_data | input | DATA_W | Header or payload word |
| late_cnt | output | CNT_W | Rejected packet count, input domain |
| rd_clk | input | 1 | Output stream clock |
| rd_rst_n | input | 1 | Active-low reset, output domain |
| start_fill | input | log2(SLOTS)+1 | Filled-slot count that starts playback |
| out_run | output | 1 | Playback has started |
| out_data | output | DATA_W | Output word, FILL_WORD when not valid |
| out_dvalid | output | 1 | Output word carries packet data |
| out_sync | output | 1 | First word of a slot period |

The input has a valid/ready handshake but never stalls. The output has no ready: it is a fixed-rate stream, and a consumer must take every word.

## Verification
The filled state of a slot reaches the output domain two rd_clk edges after the packet's last word is taken. Playback can start one edge after that. Each slot's words then appear on out_data on consecutive rd_clk cycles, starting one edge after the slot is opened, with out_sync on the first word. late_cnt changes on the input edge that takes the rejected header or last word. The bench therefore does not match output against absolute time. It samples on falling rd_clk edges, counts out_sync pulses to index slots, and compares each slot's words against values computed from which packets it chose to send. Senders are gated on the observed slot index, and late_cnt is read only after the offending packet has fully entered.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    PO_IDLE = 1'b0,
    PO_RUN  = 1'b1
  } po_state_e;
endpackage

// File: rtl/rob_gray_xfer.sv
// Moves a binary counter value across clock domains as Gray code.
module rob_gray_xfer #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_q;
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= src_bin ^ (src_bin >> 1);

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end

  always_comb
    for (int i = 0; i < W; i++) dst_bin[i] = ^(s2_q >> i);
endmodule

// File: rtl/rob_flag_sync.sv
// Two-stage synchroniser for a vector of independent level flags.
module rob_flag_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        q[i]      <= meta_q[i];
      end
  end
endmodule

// File: rtl/rob_slot_ram.sv
// Dual-clock simple dual-port packet memory, registered read.
module rob_slot_ram #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  always_ff @(posedge rclk)
    rdata <= mem[raddr];
endmodule

// File: rtl/rob_ingest.sv
// Input side: header parse, window test, payload write, slot flags.
module rob_ingest #(
  parameter int DW        = 32,
  parameter int NSLOT     = 32,
  parameter int PKT_WORDS = 64,
  parameter int HDR_WORDS = 4,
  parameter int SEQ_W     = 16,
  parameter int CNT_W     = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  output logic                                          in_ready,
  input  logic [DW-1:0]                                 in_data,
  input  logic [SEQ_W-1:0]                              rd_next,
  output logic                                          wr_en,
  output logic [$clog2(NSLOT)+$clog2(PKT_WORDS)-1:0]    wr_addr,
  output logic [DW-1:0]                                 wr_data,
  output logic [NSLOT-1:0]                              flags,
  output logic [CNT_W-1:0]                              late_cnt
);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int WRD_W  = $clog2(PKT_WORDS);
  localparam int TOT    = HDR_WORDS + PKT_WORDS;
  localparam int POS_W  = $clog2(TOT);

  logic [POS_W-1:0] pos_q;
  logic [SEQ_W-1:0] seq_q;
  logic             keep_q;
  logic             rdy_q;
  logic [CNT_W-1:0] late_q;
  logic [NSLOT-1:0] flag_q;

  function automatic logic in_win(input logic [SEQ_W-1:0] s,
                                  input logic [SEQ_W-1:0] r);
    logic [SEQ_W-1:0] d;
    d = s - r;
    return d < SEQ_W'(NSLOT - 1);
  endfunction

  logic             beat, hdr0, last_w, is_data;
  logic             win_hdr, win_end, commit, reject;
  logic [POS_W-1:0] dofs;
  logic [SEQ_W-1:0] in_seq, clr_seq;

  assign beat    = in_valid && rdy_q;
  assign hdr0    = (pos_q == '0);
  assign last_w  = (pos_q == POS_W'(TOT - 1));
  assign is_data = (pos_q >= POS_W'(HDR_WORDS));
  assign in_seq  = in_data[SEQ_W-1:0];
  assign win_hdr = in_win(in_seq, rd_next);
  assign win_end = in_win(seq_q, rd_next);
  assign commit  = beat && last_w && keep_q && win_end;
  assign reject  = beat && ((hdr0 && !win_hdr) || (last_w && keep_q && !win_end));
  assign dofs    = pos_q - POS_W'(HDR_WORDS);
  assign clr_seq = rd_next - SEQ_W'(1);

  assign wr_en    = beat && is_data && keep_q;
  assign wr_addr  = {seq_q[SLOT_W-1:0], dofs[WRD_W-1:0]};
  assign wr_data  = in_data;
  assign in_ready = rdy_q;
  assign late_cnt = late_q;
  assign flags    = flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_q  <= '0;
      seq_q  <= '0;
      keep_q <= 1'b0;
      rdy_q  <= 1'b0;
      late_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (beat) begin
        pos_q <= last_w ? '0 : pos_q + POS_W'(1);
        if (hdr0) begin
          seq_q  <= in_seq;
          keep_q <= win_hdr;
        end
      end
      if (reject) late_q <= late_q + CNT_W'(1);
    end

  // Slot just opened by the output is cleared every cycle; a commit wins.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else begin
      flag_q[clr_seq[SLOT_W-1:0]] <= 1'b0;
      if (commit) flag_q[seq_q[SLOT_W-1:0]] <= 1'b1;
    end

  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
  a_r4_late_step: assert property (@(posedge clk) disable iff (!rst_n)
    (late_cnt != $past(late_cnt)) |-> (late_cnt == $past(late_cnt) + CNT_W'(1)));
endmodule

// File: rtl/rob_playout.sv
// Output side: start gate, in-order slot walk, sync/valid rebuild.
module rob_playout
  import rob_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          NSLOT     = 32,
  parameter int          PKT_WORDS = 64,
  parameter int          SEQ_W     = 16,
  parameter logic [31:0] FILL      = 32'hA5A5_5A5A
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [$clog2(NSLOT):0]                     start_fill,
  input  logic [NSLOT-1:0]                           flags_s,
  output logic [SEQ_W-1:0]                           rd_next,
  output logic [$clog2(NSLOT)+$clog2(PKT_WORDS)-1:0] rd_addr,
  input  logic [DW-1:0]                              rd_q,
  output logic                                       out_run,
  output logic [DW-1:0]                              out_data,
  output logic                                       out_dvalid,
  output logic                                       out_sync
);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int WRD_W  = $clog2(PKT_WORDS);

  po_state_e         st_q;
  logic [WRD_W-1:0]  wcnt_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [SLOT_W-1:0] cur_q;
  logic              hit_q, dv_q, sy_q;

  logic              opening, hit_now;
  logic [SLOT_W-1:0] slot_now;
  logic [SLOT_W:0]   filled;

  assign opening  = (st_q == PO_RUN) && (wcnt_q == '0);
  assign slot_now = opening ? seq_q[SLOT_W-1:0] : cur_q;
  assign hit_now  = opening ? flags_s[seq_q[SLOT_W-1:0]] : hit_q;
  assign rd_addr  = {slot_now, wcnt_q};
  assign rd_next  = seq_q;

  always_comb begin
    filled = '0;
    for (int i = 0; i < NSLOT; i++) filled = filled + (SLOT_W + 1)'(flags_s[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= PO_IDLE;
      wcnt_q <= '0;
      seq_q  <= '0;
      cur_q  <= '0;
      hit_q  <= 1'b0;
      dv_q   <= 1'b0;
      sy_q   <= 1'b0;
    end else begin
      dv_q <= (st_q == PO_RUN) && hit_now;
      sy_q <= opening;
      case (st_q)
        PO_IDLE: if (filled >= start_fill) st_q <= PO_RUN;
        default: begin
          wcnt_q <= wcnt_q + WRD_W'(1);
          if (opening) begin
            seq_q <= seq_q + SEQ_W'(1);
            cur_q <= slot_now;
            hit_q <= hit_now;
          end
        end
      endcase
    end

  assign out_run    = (st_q == PO_RUN);
  assign out_dvalid = dv_q;
  assign out_sync   = sy_q;
  assign out_data   = dv_q ? rd_q : DW'(FILL);

  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_run |=> out_run);
  a_r6_sync_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_run);
  a_r6_sync_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |=> !out_sync);
  a_r7_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sync && !out_dvalid) |=> !out_dvalid);
  a_r8_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sync && out_dvalid) |=> out_dvalid);
  a_r5_dvalid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_dvalid |-> out_run);
endmodule

// File: rtl/seq_reorder_buf.sv
module seq_reorder_buf #(
  parameter int          DATA_W    = 32,
  parameter int          SLOTS     = 32,
  parameter int          PKT_WORDS = 64,
  parameter int          HDR_WORDS = 4,
  parameter int          SEQ_W     = 16,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] FILL_WORD = 32'hA5A5_5A5A
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  output logic [CNT_W-1:0]         late_cnt,
  input  logic                     rd_clk,
  input  logic                     rd_rst_n,
  input  logic [$clog2(SLOTS):0]   start_fill,
  output logic                     out_run,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_dvalid,
  output logic                     out_sync
);
  localparam int ADDR_W = $clog2(SLOTS) + $clog2(PKT_WORDS);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_q;
  logic [SLOTS-1:0]  flags_w, flags_r;
  logic [SEQ_W-1:0]  next_r, next_w;

  rob_ingest #(
    .DW(DATA_W), .NSLOT(SLOTS), .PKT_WORDS(PKT_WORDS),
    .HDR_WORDS(HDR_WORDS), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
  ) u_ingest (
    .clk(wr_clk), .rst_n(wr_rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_next(next_w),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flags(flags_w), .late_cnt(late_cnt)
  );

  rob_slot_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .raddr(rd_addr), .rdata(rd_q)
  );

  rob_flag_sync #(.W(SLOTS)) u_flag_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(flags_w), .q(flags_r)
  );

  rob_gray_xfer #(.W(SEQ_W)) u_ptr_xfer (
    .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_bin(next_r),
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(next_w)
  );

  rob_playout #(
    .DW(DATA_W), .NSLOT(SLOTS), .PKT_WORDS(PKT_WORDS),
    .SEQ_W(SEQ_W), .FILL(FILL_WORD)
  ) u_playout (
    .clk(rd_clk), .rst_n(rd_rst_n),
    .start_fill(start_fill), .flags_s(flags_r),
    .rd_next(next_r), .rd_addr(rd_addr), .rd_q(rd_q),
    .out_run(out_run), .out_data(out_data),
    .out_dvalid(out_dvalid), .out_sync(out_sync)
  );
endmodule

// File: tb/sim_seq_reorder_buf.sv
module sim_seq_reorder_buf;
  localparam int          WR_PER = 10;
  localparam int          RD_PER = 16;
  localparam int          NS     = 8;
  localparam int          PW     = 4;
  localparam int          HW     = 2;
  localparam int          SQ     = 5;
  localparam logic [31:0] FILLV  = 32'hDEAD_BEEF;
  localparam int          NPLAY  = 50;

  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_rst_n = 0, rd_rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [7:0]  late_cnt;
  logic [3:0]  start_fill = 4'd6;
  logic        out_run, out_dvalid, out_sync;
  logic [31:0] out_data;

  int tests = 0, fails = 0;
  bit done = 0;

  seq_reorder_buf #(
    .DATA_W(32), .SLOTS(NS), .PKT_WORDS(PW), .HDR_WORDS(HW),
    .SEQ_W(SQ), .CNT_W(8), .FILL_WORD(FILLV)
  ) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .late_cnt(late_cnt),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .start_fill(start_fill),
    .out_run(out_run), .out_data(out_data),
    .out_dvalid(out_dvalid), .out_sync(out_sync)
  );

  initial forever #(WR_PER / 2) wr_clk = ~wr_clk;
  initial forever #(RD_PER / 2) rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Output collector: slot index from counted sync pulses.
  int          k_play = 0, widx = 0, gap_err = 0;
  logic [31:0] cap_d [64][PW];
  bit          cap_v [64][PW];
  bit          deliv [64];

  always @(negedge rd_clk) begin
    if (out_sync) begin
      if (k_play > 0 && widx != PW) gap_err++;
      k_play++;
      widx = 0;
    end
    if (k_play > 0 && k_play <= 64 && widx < PW) begin
      cap_d[k_play-1][widx] = out_data;
      cap_v[k_play-1][widx] = out_dvalid;
    end
    if (k_play > 0) widx++;
  end

  // R1 packet format: header word 0 low SQ bits = seq, junk elsewhere.
  task automatic send_pkt(input int u, input int seqv, input bit gaps);
    for (int p = 0; p < HW + PW; p++) begin
      logic [31:0] w;
      if (p == 0)       w = 32'hB7C3_9E40 | 32'(seqv % 32);
      else if (p < HW)  w = 32'h1234_5678 ^ 32'(u);
      else              w = {16'(u), 8'h5A, 8'(p - HW)};
      @(negedge wr_clk);
      in_valid = 1'b1;
      in_data  = w;
      if (gaps && p == HW) begin
        @(negedge wr_clk);
        in_valid = 1'b0;
      end
    end
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(RD_PER * 20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int late_exp;
    int wait_c;
    late_exp = 0;
    for (int i = 0; i < 64; i++) deliv[i] = 0;
    #(RD_PER * 5);
    @(negedge wr_clk) wr_rst_n = 1;
    @(negedge rd_clk) rd_rst_n = 1;
    repeat (3) @(negedge wr_clk);

    // Reset state
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(late_cnt == 0, "R4", "late_cnt reset", late_cnt, 0);
    @(negedge rd_clk);
    chk(out_run == 0, "R5", "out_run reset", out_run, 0);
    chk(out_dvalid == 0, "R5", "out_dvalid reset", out_dvalid, 0);
    chk(out_sync == 0, "R5", "out_sync reset", out_sync, 0);
    chk(out_data == FILLV, "R5", "out_data reset", out_data, FILLV);

    // Out-of-order fill below the start threshold of 6
    send_pkt(3, 3, 0); deliv[3] = 1;
    send_pkt(0, 0, 1); deliv[0] = 1;
    send_pkt(5, 5, 0); deliv[5] = 1;
    send_pkt(1, 1, 1); deliv[1] = 1;
    send_pkt(4, 4, 0); deliv[4] = 1;
    repeat (20) @(negedge rd_clk);
    chk(out_run == 0, "R5", "idle with 5 filled slots", out_run, 0);
    chk(k_play == 0 && out_dvalid == 0, "R5", "no output before start", k_play, 0);

    // seq 7 is SLOTS-1 ahead of P=0: outside the window
    send_pkt(7, 7, 0); late_exp++;
    repeat (4) @(negedge wr_clk);
    chk(late_cnt == 8'(late_exp), "R3 R4", "window edge rejected", late_cnt, late_exp);

    send_pkt(6, 6, 0); deliv[6] = 1;
    wait_c = 0;
    while (!out_run && wait_c < 40) begin @(negedge rd_clk); wait_c++; end
    chk(out_run == 1, "R5", "start at threshold", out_run, 1);

    // Streaming phase across the sequence wrap (R10)
    for (int u = 7; u < 46; u++) begin
      while (u > k_play + 4) @(negedge rd_clk);
      if (u == 20 || u == 30) begin
        send_pkt(900 + u, (k_play - 4) & 31, 0); late_exp++;
      end
      if (u == 25) begin
        send_pkt(900 + u, (k_play + 11) & 31, 0); late_exp++;
      end
      if (u % 5 == 2) continue;
      if (u < k_play + 2) continue;
      send_pkt(u, u % 32, u % 3 == 0);
      deliv[u] = 1;
    end

    while (k_play < NPLAY + 1) @(negedge rd_clk);

    for (int k = 0; k < NPLAY; k++) begin
      bit   ok;
      int   bad;
      string tag;
      ok  = 1;
      bad = 0;
      for (int j = 0; j < PW; j++) begin
        logic [31:0] e;
        e = deliv[k] ? {16'(k), 8'h5A, 8'(j)} : FILLV;
        if (ok && (cap_d[k][j] != e || cap_v[k][j] != deliv[k])) begin
          ok = 0;
          bad = j;
        end
      end
      if (deliv[k])                        tag = (k >= 32) ? "R2 R8 R10" : "R1 R2 R8";
      else if (k >= NS && deliv[k - NS])   tag = "R9";
      else                                 tag = (k >= 32) ? "R7 R10" : "R7";
      chk(ok, tag, $sformatf("slot %0d word %0d", k, bad),
          {cap_v[k][bad], cap_d[k][bad]},
          {deliv[k], (deliv[k] ? {16'(k), 8'h5A, 8'(bad)} : FILLV)});
    end

    chk(gap_err == 0, "R6", "sync period of PKT_WORDS", gap_err, 0);
    @(negedge wr_clk);
    chk(late_cnt == 8'(late_exp), "R3 R4", "late total", late_cnt, late_exp);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule